// File: doc/BRIEF.md
# PSRAM Low-Power Mode Sequencer

This block drives the sleep-control pin, chip enable, write enable and the five low address bits of an asynchronous pseudo-static RAM. It handles the low-power side of the part: programming its address-space configuration register, putting it into deep sleep, and putting it into partial-refresh standby. The host asks for one operation at a time on a valid/ready request port. Before the sequencer touches any pin it borrows the memory bus from the normal access controller through a request/grant pair. It hands the bus back when the operation, including any recovery wait, is finished.

The configuration code sits on address bits 0 to 4. It is written by a chip-enable/write-enable cycle while the sleep pin is held low, and only after a settling time has passed. A shadow copy of the last code that was written becomes an address window, given as a base and a limit. An address-check port flags host addresses that fall outside that window. Deep sleep loses the memory contents. It enforces a minimum time asleep, and after waking it holds the bus for a long recovery time. Partial-refresh standby ends as soon as the host wakes it.

Back-pressure: `req_ready` is high only while the sequencer is idle. A request is taken in a cycle where `req_valid` and `req_ready` are both high and the request is legal. A request that is not taken is never queued. It is dropped, and `req_rej` pulses in the next cycle.

Top module: `lpm_seq`

## Requirements
- R1: After reset the sleep pin is high, chip enable and write enable are high (inactive), `bus_req` and `ps_own` are low, `req_ready` is high, and the window spans the whole array (0 to all ones).
- R2: A request presented while `req_ready` is low is dropped. `req_rej` is high in the next cycle, and neither the pins, `bus_req` nor the window change because of it.
- R3: `bus_req` rises in the cycle after a request is taken. While `bus_gnt` is low the sequencer holds the sleep pin high, holds chip enable and write enable inactive, and keeps `ps_own` low.
- R4: A register program, once granted, holds the sleep pin low with chip enable high for T_SETUP cycles. It then holds chip enable and write enable low together for T_WR cycles, and then holds both high with the sleep pin still low for one cycle. In the next cycle the sleep pin rises, `bus_req` falls and `req_ready` returns.
- R5: During the write the code on `ps_code` is: bit 4 = 1; bit 3 = 1 for reduced size (req_op 00), 0 for partial refresh (req_op 01); bit 2 = `req_top` (1 = top of array); bits 1:0 = `req_frac`, where 11 is a quarter, 10 a half, 01 three quarters and 00 the full array.
- R6: A partial-refresh program request with `req_frac` = 00 is illegal. It is rejected with `req_rej` and starts nothing.
- R7: After a reduced-size program the window covers n quarters of the array, where n = 4 − `req_frac`. At the bottom it runs from 0 to n·Q−1, and at the top from (4−n)·Q to all ones, with Q = 2^(ADDR_W−2). With ADDR_W = 20, three quarters at the top gives 40000h to FFFFFh.
- R8: After a partial-refresh program the window spans the whole array.
- R9: `chk_oob` is high exactly when `chk_addr` is below the window base or above the window limit.
- R10: Deep sleep (req_op 10) holds the sleep pin low with chip enable high for at least T_MIN cycles, even if `wake` is already high. It ends in the first cycle in which `wake` is high and T_MIN cycles have passed.
- R11: After deep sleep the sleep pin is high but `bus_req` stays high for T_REC more cycles. Then the bus is released and `req_ready` returns.
- R12: Standby (req_op 11) holds the sleep pin low until `wake` is seen. It has no minimum time and no recovery wait, and the window is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_op | input | 2 | 00 reduced size, 01 partial refresh, 10 deep sleep, 11 standby |
| req_top | input | 1 | Active region at top of array |
| req_frac | input | 2 | Active fraction code |
| req_rej | output | 1 | Previous-cycle request dropped |
| wake | input | 1 | Leave sleep or standby |
| bus_req | output | 1 | Memory bus wanted |
| bus_gnt | input | 1 | Memory bus granted |
| ps_own | output | 1 | Sequencer is driving the memory pins |
| ps_zz | output | 1 | Sleep pin, low active |
| ps_ce_n | output | 1 | Chip enable, low active |
| ps_we_n | output | 1 | Write enable, low active |
| ps_code | output | 5 | Address bits 0 to 4 |
| win_base | output | ADDR_W | Lowest usable address |
| win_limit | output | ADDR_W | Highest usable address |
| chk_addr | input | ADDR_W | Address to check |
| chk_oob | output | 1 | Checked address outside window |

## Verification
The interesting collision is a new request that lands in the final cycle of a register program, while the write has ended but the sleep pin is still low and the sequencer is not yet idle. The bench provokes this by watching for write enable to rise and presenting a deep-sleep request in exactly that cycle. It then expects `req_rej` one cycle later, `bus_req` low, the sleep pin high and the window still equal to the code that just finished. This shows that the finish and the new arrival do not merge into a sleep sequence.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    OP_SHRINK  = 2'b00,
    OP_PARPROG = 2'b01,
    OP_DEEP    = 2'b10,
    OP_STBY    = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_GRANT, S_SETUP, S_WRITE, S_WEND, S_SLEEP, S_RECOV
  } st_e;
endpackage

// File: rtl/lpm_encode.sv
module lpm_encode
  import lpm_pkg::*;
(
  input  op_e        op,
  input  logic       top,
  input  logic [1:0] frac,
  output logic [4:0] code,
  output logic       illegal
);
  // bit4 fixed, bit3 selects shrink vs refresh, bit2 placement, bits1:0 fraction
  always_comb begin
    code    = {1'b1, (op == OP_SHRINK), top, frac};
    illegal = (op == OP_PARPROG) && (frac == 2'b00);
  end
endmodule

// File: rtl/lpm_range.sv
module lpm_range #(
  parameter int ADDR_W = 20
) (
  input  logic [4:0]        code,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] limit,
  output logic              oob
);
  localparam int QS = ADDR_W - 2;

  logic [2:0]      quarters;
  logic [ADDR_W:0] span;

  always_comb begin
    quarters = 3'd4 - {1'b0, code[1:0]};
    span     = (ADDR_W+1)'(quarters) << QS;
    if (code[4] && code[3]) begin
      if (code[2]) begin
        base  = {code[1:0], {QS{1'b0}}};
        limit = '1;
      end else begin
        base  = '0;
        limit = ADDR_W'(span - 1'b1);
      end
    end else begin
      base  = '0;
      limit = '1;
    end
    oob = (addr < base) || (addr > limit);
  end
endmodule

// File: rtl/lpm_timer.sv
module lpm_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int T_SETUP = 50,
  parameter int T_WR    = 4,
  parameter int T_MIN   = 400,
  parameter int T_REC   = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic              req_top,
  input  logic [1:0]        req_frac,
  output logic              req_rej,
  input  logic              wake,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              ps_own,
  output logic              ps_zz,
  output logic              ps_ce_n,
  output logic              ps_we_n,
  output logic [4:0]        ps_code,
  output logic [ADDR_W-1:0] win_base,
  output logic [ADDR_W-1:0] win_limit,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              chk_oob
);
  localparam int TM1   = (T_SETUP > T_WR) ? T_SETUP : T_WR;
  localparam int TM2   = (T_MIN > T_REC) ? T_MIN : T_REC;
  localparam int TMAX  = (TM1 > TM2) ? TM1 : TM2;
  localparam int CNT_W = $clog2(TMAX + 1);
  localparam logic [4:0] CODE_FULL = 5'b11000;

  st_e              st, nxt;
  op_e              op_q;
  logic [4:0]       code_q, shadow, new_code;
  logic             illegal, accept, tmr_ld, tmr_zero, deep_q;
  logic [CNT_W-1:0] tmr_val;

  lpm_encode u_enc (
    .op(op_e'(req_op)), .top(req_top), .frac(req_frac),
    .code(new_code), .illegal(illegal)
  );

  lpm_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_ld), .load_val(tmr_val), .zero(tmr_zero)
  );

  lpm_range #(.ADDR_W(ADDR_W)) u_rng (
    .code(shadow), .addr(chk_addr), .base(win_base), .limit(win_limit), .oob(chk_oob)
  );

  assign req_ready = (st == S_IDLE);
  assign accept    = req_valid && req_ready && !illegal;
  assign deep_q    = (op_q == OP_DEEP);

  always_comb begin
    nxt     = st;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    case (st)
      S_IDLE:  if (accept) nxt = S_GRANT;
      S_GRANT: if (bus_gnt) begin
        tmr_ld = 1'b1;
        if (op_q == OP_SHRINK || op_q == OP_PARPROG) begin
          nxt     = S_SETUP;
          tmr_val = CNT_W'(T_SETUP - 1);
        end else begin
          nxt     = S_SLEEP;
          tmr_val = CNT_W'(T_MIN - 1);
        end
      end
      S_SETUP: if (tmr_zero) begin
        nxt     = S_WRITE;
        tmr_ld  = 1'b1;
        tmr_val = CNT_W'(T_WR - 1);
      end
      S_WRITE: if (tmr_zero) nxt = S_WEND;
      S_WEND:  nxt = S_IDLE;
      S_SLEEP: if (wake && (tmr_zero || !deep_q)) begin
        if (deep_q) begin
          nxt     = S_RECOV;
          tmr_ld  = 1'b1;
          tmr_val = CNT_W'(T_REC - 1);
        end else begin
          nxt = S_IDLE;
        end
      end
      S_RECOV: if (tmr_zero) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      op_q    <= OP_SHRINK;
      code_q  <= CODE_FULL;
      shadow  <= CODE_FULL;
      req_rej <= 1'b0;
    end else begin
      st      <= nxt;
      req_rej <= req_valid && (!req_ready || illegal);
      if (accept) begin
        op_q   <= op_e'(req_op);
        code_q <= new_code;
      end
      if (st == S_WRITE && tmr_zero) shadow <= code_q;
    end
  end

  always_comb begin
    bus_req = (st != S_IDLE);
    ps_own  = (st != S_IDLE) && (st != S_GRANT);
    ps_zz   = !(st == S_SETUP || st == S_WRITE || st == S_WEND || st == S_SLEEP);
    ps_ce_n = (st != S_WRITE);
    ps_we_n = (st != S_WRITE);
    ps_code = (st == S_WRITE) ? code_q : 5'b0;
  end

  // Independent sleep-length counter used only by the minimum-sleep check
  logic [CNT_W-1:0] sleep_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 sleep_len <= '0;
    else if (st == S_SLEEP)     sleep_len <= (sleep_len == '1) ? sleep_len : sleep_len + 1'b1;
    else                        sleep_len <= '0;
  end

  // R4
  wr_in_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ps_we_n |-> (!ps_zz && !ps_ce_n));

  // R5
  code_lead_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ps_we_n |-> ps_code[4]);

  // R3
  own_after_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ps_own) |-> $past(bus_gnt));

  // R7
  window_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_base <= win_limit);

  // R2
  window_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |=> ($stable(win_base) && $stable(win_limit)));

  // R10
  sleep_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ps_zz) && st == S_RECOV) |-> (sleep_len >= CNT_W'(T_MIN)));
endmodule

// File: tb/test_lpm_seq.sv
module test_lpm_seq;
  localparam int AW = 20;
  localparam int TS = 5;
  localparam int TW = 3;
  localparam int TM = 20;
  localparam int TR = 40;

  typedef struct packed {
    logic [1:0]    op;
    logic          top;
    logic [1:0]    frac;
    logic [4:0]    code;
    logic [AW-1:0] base;
    logic [AW-1:0] limit;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'b00, 1'b0, 2'b11, 5'b11011, 20'h00000, 20'h3FFFF},
    '{2'b00, 1'b1, 2'b01, 5'b11101, 20'h40000, 20'hFFFFF},
    '{2'b00, 1'b0, 2'b10, 5'b11010, 20'h00000, 20'h7FFFF},
    '{2'b00, 1'b1, 2'b11, 5'b11111, 20'hC0000, 20'hFFFFF},
    '{2'b00, 1'b0, 2'b01, 5'b11001, 20'h00000, 20'hBFFFF},
    '{2'b01, 1'b1, 2'b10, 5'b10110, 20'h00000, 20'hFFFFF},
    '{2'b00, 1'b1, 2'b00, 5'b11100, 20'h00000, 20'hFFFFF},
    '{2'b00, 1'b1, 2'b10, 5'b11110, 20'h80000, 20'hFFFFF}
  };

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_top = 0, wake = 0, gnt_en = 1;
  logic [1:0] req_op = 0, req_frac = 0;
  logic [AW-1:0] chk_addr = 0;
  logic req_ready, req_rej, bus_req, bus_gnt, ps_own, ps_zz, ps_ce_n, ps_we_n, chk_oob;
  logic [4:0] ps_code;
  logic [AW-1:0] win_base, win_limit;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;
  assign bus_gnt = gnt_en & bus_req;

  lpm_seq #(.ADDR_W(AW), .T_SETUP(TS), .T_WR(TW), .T_MIN(TM), .T_REC(TR)) i_lpm_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_top(req_top), .req_frac(req_frac), .req_rej(req_rej),
    .wake(wake), .bus_req(bus_req), .bus_gnt(bus_gnt), .ps_own(ps_own),
    .ps_zz(ps_zz), .ps_ce_n(ps_ce_n), .ps_we_n(ps_we_n), .ps_code(ps_code),
    .win_base(win_base), .win_limit(win_limit), .chk_addr(chk_addr), .chk_oob(chk_oob)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic send(input logic [1:0] op, input logic top, input logic [1:0] frac);
    req_op = op; req_top = top; req_frac = frac; req_valid = 1;
    tick();
    req_valid = 0;
  endtask

  task automatic wait_zz_low();
    for (int i = 0; i < 100 && ps_zz; i++) tick();
  endtask

  // follows one register program from grant to release; leaves bench in final zz-low cycle
  task automatic run_prog_to_end(input logic [4:0] code);
    int n;
    wait_zz_low();
    n = 0;
    while (!ps_zz && ps_we_n && n < 100) begin n++; tick(); end
    chk("R4 setup length", n, TS);
    n = 0;
    while (!ps_we_n && n < 100) begin
      chk("R5 code on pins", ps_code, code);
      chk("R4 ce low with we", ps_ce_n, 0);
      n++; tick();
    end
    chk("R4 write length", n, TW);
    chk("R4 zz low after write", ps_zz, 0);
  endtask

  task automatic run_prog(input logic [4:0] code);
    run_prog_to_end(code);
    tick();
    chk("R4 zz high at end", ps_zz, 1);
    chk("R4 bus released", bus_req, 0);
    chk("R4 ready again", req_ready, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1;
    tick();
    // R1 reset state
    chk("R1 zz", ps_zz, 1);
    chk("R1 ce_n", ps_ce_n, 1);
    chk("R1 we_n", ps_we_n, 1);
    chk("R1 bus_req", bus_req, 0);
    chk("R1 own", ps_own, 0);
    chk("R1 ready", req_ready, 1);
    chk("R1 base", win_base, 0);
    chk("R1 limit", win_limit, 20'hFFFFF);

    // vector walk: R5 codes, R7/R8 windows, R9 flag
    for (int v = 0; v < 8; v++) begin
      send(VECS[v].op, VECS[v].top, VECS[v].frac);
      run_prog(VECS[v].code);
      chk(VECS[v].op == 2'b01 ? "R8 base" : "R7 base", win_base, VECS[v].base);
      chk(VECS[v].op == 2'b01 ? "R8 limit" : "R7 limit", win_limit, VECS[v].limit);
      chk_addr = VECS[v].base; #1;
      chk("R9 at base", chk_oob, 0);
      chk_addr = VECS[v].limit; #1;
      chk("R9 at limit", chk_oob, 0);
      if (VECS[v].base != 0) begin
        chk_addr = VECS[v].base - 1; #1;
        chk("R9 below base", chk_oob, 1);
      end
      if (VECS[v].limit != 20'hFFFFF) begin
        chk_addr = VECS[v].limit + 1; #1;
        chk("R9 above limit", chk_oob, 1);
      end
      tick();
    end

    // R2: request in the last cycle of a program is dropped
    send(2'b00, 1'b1, 2'b01);
    run_prog_to_end(5'b11101);
    req_op = 2'b10; req_valid = 1;
    tick();
    req_valid = 0;
    chk("R2 reject pulse", req_rej, 1);
    chk("R2 zz high", ps_zz, 1);
    chk("R2 no bus", bus_req, 0);
    tick();
    chk("R2 still idle", bus_req, 0);
    chk("R2 pulse ends", req_rej, 0);
    chk("R7 three-quarter top base", win_base, 20'h40000);

    // R3: no pin activity before grant
    gnt_en = 0;
    send(2'b00, 1'b0, 2'b11);
    for (int i = 0; i < 5; i++) begin
      chk("R3 bus_req held", bus_req, 1);
      chk("R3 zz idle", ps_zz, 1);
      chk("R3 ce idle", ps_ce_n, 1);
      chk("R3 not owned", ps_own, 0);
      tick();
    end
    gnt_en = 1;
    run_prog(5'b11011);

    // R6: illegal refresh fraction
    send(2'b01, 1'b0, 2'b00);
    chk("R6 reject", req_rej, 1);
    chk("R6 no bus", bus_req, 0);
    tick();
    chk("R6 zz high", ps_zz, 1);
    chk("R6 window kept", win_limit, 20'h3FFFF);

    // R10/R11: deep sleep with early wake
    wake = 1;
    send(2'b10, 1'b0, 2'b00);
    wait_zz_low();
    begin
      int n = 0;
      while (!ps_zz && n < 200) begin
        chk("R10 ce high asleep", ps_ce_n, 1);
        n++; tick();
      end
      chk("R10 minimum sleep", n, TM);
      n = 0;
      while (bus_req && n < 200) begin n++; tick(); end
      chk("R11 recovery length", n, TR);
      chk("R11 ready", req_ready, 1);
    end

    // R10: late wake
    wake = 0;
    send(2'b10, 1'b0, 2'b00);
    wait_zz_low();
    repeat (TM + 5) tick();
    chk("R10 held without wake", ps_zz, 0);
    wake = 1;
    tick();
    chk("R10 exit after wake", ps_zz, 1);
    chk("R11 bus held", bus_req, 1);
    for (int i = 0; i < 200 && bus_req; i++) tick();

    // R12: standby
    wake = 0;
    send(2'b11, 1'b0, 2'b00);
    wait_zz_low();
    tick(); tick();
    chk("R12 zz low", ps_zz, 0);
    wake = 1;
    tick();
    chk("R12 zz high", ps_zz, 1);
    chk("R12 no recovery", bus_req, 0);
    chk("R12 window kept", win_limit, 20'h3FFFF);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule